// File: doc/BRIEF.md
# LIN Break and Sync Discriminator

This block watches the LIN receive line of a slave node and decides, cycle by cycle on the core clock, whether a low period on the line is a break, the first low bit of the sync byte, or ordinary frame traffic. The line is brought into the clock domain through a synchroniser. A counter then measures each low period in clock ticks. A classifier compares the finished low period with a programmable minimum break length, and while the sync byte is being timed it can also compare it with a fixed sync-bit limit.

When a valid break is seen, the block emits a one-cycle break pulse. In the same cycle it emits a strobe that the surrounding controller uses to clear its transmit/receive mode flag, which returns the node to receive mode. With second-break discrimination enabled, a sync start bit that is too long to be sync is treated as a candidate break: its low time keeps being counted, and it is accepted as a break if it reaches the minimum break length. The block also counts the falling edges seen since the last break and raises a sticky error flag when a frame carries too many of them.

Top module: `lin_brk_disc`

## Requirements
- R1: `rx_in` passes through a two-stage synchroniser whose flops reset to the idle-high level. After reset, `brk_pulse`, `mode_clr`, `sync_ok` and `edge_err` are all 0.
- R2: While the block waits for a break (idle, or inside a frame), a low period ends with a single one-cycle `brk_pulse` if its length in clock ticks is at least `min_brk_len`, sampled when the line returns high. A shorter low period gives no pulse.
- R3: `mode_clr` pulses for exactly the cycles in which `brk_pulse` is 1.
- R4: With `disc_en` = 0, the first low period after a break is always taken as the sync start bit, whatever its length. It produces one `sync_ok` pulse and no break.
- R5: With `disc_en` = 1, a first low period after a break that is shorter than SYNC_LIMIT (default 750) ticks produces one `sync_ok` pulse. A length of 749 still qualifies.
- R6: With `disc_en` = 1, a first low period of at least SYNC_LIMIT ticks that also reaches `min_brk_len` is reported as a new break (`brk_pulse`, `mode_clr`) and produces no `sync_ok`.
- R7: With `disc_en` = 1, a first low period of at least SYNC_LIMIT ticks but shorter than `min_brk_len` produces neither pulse. The block then returns to waiting for a break, so a following short low period gives no `sync_ok`.
- R8: Each falling edge of the synchronised line after the most recent break is counted. `edge_err` rises when the count exceeds EDGE_MAX (default 57): 57 edges leave it at 0, and the 58th sets it. The flag stays set.
- R9: A detected break clears the edge count and `edge_err` in the cycle its `brk_pulse` is 1.
- R10: While `en` is 0, all counters, the classifier state and all outputs are held in reset, so a break-length low period produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; 0 holds the block in reset |
| rx_in | input | 1 | Raw LIN receive line, idle high |
| disc_en | input | 1 | Enables the second-break check on the sync start bit |
| min_brk_len | input | CNT_W | Minimum break length in clock ticks |
| brk_pulse | output | 1 | One-cycle pulse on a recognised break |
| mode_clr | output | 1 | Strobe that clears the transmit/receive mode flag |
| sync_ok | output | 1 | One-cycle pulse when a valid sync start bit ends |
| edge_err | output | 1 | Sticky flag for too many falling edges in a frame |

## Verification
If the classifier state is wrong, the effect shows at the end of the next low period on the line. The block then gives the wrong pulse, or none: `sync_ok` where a break should appear, or the reverse, two ticks of synchroniser latency plus one register after the line returns high. A low-time count that is off by one shows up only in the boundary tests, at 749 and 750 ticks against the sync limit and at the exact minimum break length. A faulty edge count shows up as `edge_err` rising one edge early or late around the 57th and 58th falling edge, or as a flag that survives a break.

// File: rtl/lin_bsd_pkg.sv
package lin_bsd_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_ARMED = 2'd1,
      ST_SYNCB = 2'd2,
      ST_FRAME = 2'd3
   } cls_state_t;

   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((32'd1 << n) <= v) n++;
      return n;
   endfunction

endpackage

// File: rtl/lin_bsd_sync.sv
module lin_bsd_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lin_bsd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= IDLE_LV;
            else        chain[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LV;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/lin_bsd_lowtimer.sv
module lin_bsd_lowtimer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             line_s,
   output logic             fall,
   output logic             rise,
   output logic [CNT_W-1:0] low_len
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic line_d;

   assign fall = line_d & ~line_s;
   assign rise = ~line_d & line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d  <= 1'b1;
         low_len <= '0;
      end else if (hold) begin
         line_d  <= 1'b1;
         low_len <= '0;
      end else begin
         line_d <= line_s;
         if (!line_s) begin
            if (line_d)                 low_len <= CNT_W'(1);
            else if (low_len != CNT_TOP) low_len <= low_len + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lin_bsd_edgecnt.sv
module lin_bsd_edgecnt #(
   parameter int unsigned EDGE_MAX = 57
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic fall,
   input  logic restart,
   output logic too_many
);
   localparam int unsigned          EW  = lin_bsd_pkg::bits_for(EDGE_MAX + 1);
   localparam logic [EW-1:0]        TOP = EW'(EDGE_MAX + 1);

   if (EDGE_MAX < 1) begin : g_bad_max
      $error("lin_bsd_edgecnt: EDGE_MAX must be at least 1");
   end

   logic [EW-1:0] n_edges;
   logic [EW-1:0] n_next;

   always_comb begin
      n_next = n_edges;
      if (fall && n_edges != TOP) n_next = n_edges + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_edges  <= '0;
         too_many <= 1'b0;
      end else if (hold || restart) begin
         n_edges  <= '0;
         too_many <= 1'b0;
      end else begin
         n_edges <= n_next;
         if (n_next == TOP) too_many <= 1'b1;
      end
   end
endmodule

// File: rtl/lin_bsd_classify.sv
module lin_bsd_classify
   import lin_bsd_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned SYNC_LIMIT = 750
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             fall,
   input  logic             rise,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] min_len,
   input  logic             disc_en,
   output logic             brk_now,
   output logic             brk_q,
   output logic             clr_q,
   output logic             sync_q
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(SYNC_LIMIT);

   cls_state_t st, st_nx;
   logic       sync_now;
   logic       long_low;
   logic       brk_len;

   assign long_low = (low_len >= LIM);
   assign brk_len  = (low_len >= min_len);

   always_comb begin
      st_nx    = st;
      brk_now  = 1'b0;
      sync_now = 1'b0;
      unique case (st)
         ST_HUNT, ST_FRAME: begin
            if (rise && brk_len) begin
               brk_now = 1'b1;
               st_nx   = ST_ARMED;
            end
         end
         ST_ARMED: begin
            if (fall) st_nx = ST_SYNCB;
         end
         ST_SYNCB: begin
            if (rise) begin
               if (disc_en && long_low) begin
                  if (brk_len) begin
                     brk_now = 1'b1;
                     st_nx   = ST_ARMED;
                  end else begin
                     st_nx = ST_HUNT;
                  end
               end else begin
                  sync_now = 1'b1;
                  st_nx    = ST_FRAME;
               end
            end
         end
         default: st_nx = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_HUNT;
         brk_q  <= 1'b0;
         clr_q  <= 1'b0;
         sync_q <= 1'b0;
      end else if (hold) begin
         st     <= ST_HUNT;
         brk_q  <= 1'b0;
         clr_q  <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         st     <= st_nx;
         brk_q  <= brk_now;
         clr_q  <= brk_now;
         sync_q <= sync_now;
      end
   end
endmodule

// File: rtl/lin_brk_disc.sv
module lin_brk_disc #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_LIMIT  = 750,
   parameter int unsigned EDGE_MAX    = 57,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rx_in,
   input  logic             disc_en,
   input  logic [CNT_W-1:0] min_brk_len,
   output logic             brk_pulse,
   output logic             mode_clr,
   output logic             sync_ok,
   output logic             edge_err
);
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_w
      $error("lin_brk_disc: CNT_W out of range");
   end
   if (SYNC_LIMIT >= (1 << CNT_W)) begin : g_bad_lim
      $error("lin_brk_disc: SYNC_LIMIT does not fit CNT_W");
   end

   logic             hold;
   logic             rx_s;
   logic             fall, rise;
   logic [CNT_W-1:0] low_len;
   logic             brk_now;

   assign hold = ~en;

   lin_bsd_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rx_in), .q_out(rx_s)
   );

   lin_bsd_lowtimer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .hold(hold), .line_s(rx_s),
      .fall(fall), .rise(rise), .low_len(low_len)
   );

   lin_bsd_classify #(.CNT_W(CNT_W), .SYNC_LIMIT(SYNC_LIMIT)) u_cls (
      .clk(clk), .rst_n(rst_n), .hold(hold), .fall(fall), .rise(rise),
      .low_len(low_len), .min_len(min_brk_len), .disc_en(disc_en),
      .brk_now(brk_now), .brk_q(brk_pulse), .clr_q(mode_clr), .sync_q(sync_ok)
   );

   lin_bsd_edgecnt #(.EDGE_MAX(EDGE_MAX)) u_edge (
      .clk(clk), .rst_n(rst_n), .hold(hold), .fall(fall),
      .restart(brk_now), .too_many(edge_err)
   );
endmodule

// File: rtl/lin_brk_disc_chk.sv
module lin_brk_disc_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             rx_s,
   input logic [CNT_W-1:0] low_len,
   input logic [CNT_W-1:0] min_brk_len,
   input logic             brk_pulse,
   input logic             mode_clr,
   input logic             sync_ok,
   input logic             edge_err
);
   p_brk_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> !brk_pulse);

   p_brk_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> ($past(rx_s) && !$past(rx_s, 2)));

   p_brk_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> ($past(low_len) >= $past(min_brk_len)));

   p_mode_with_brk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_clr == brk_pulse);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_pulse && sync_ok));

   p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> !edge_err);

   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!brk_pulse && !mode_clr && !sync_ok && !edge_err));
endmodule

bind lin_brk_disc lin_brk_disc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .rx_s(rx_s), .low_len(low_len),
   .min_brk_len(min_brk_len), .brk_pulse(brk_pulse), .mode_clr(mode_clr),
   .sync_ok(sync_ok), .edge_err(edge_err)
);

// File: tb/sim_lin_brk_disc.sv
module sim_lin_brk_disc;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          rx_in = 1'b1;
   logic          disc_en = 1'b0;
   logic [CW-1:0] min_brk_len = CW'(800);
   logic          brk_pulse, mode_clr, sync_ok, edge_err;

   int n_chk = 0, n_bad = 0;
   int n_brk = 0, n_clr = 0, n_sync = 0, n_mis = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lin_brk_disc #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .rx_in(rx_in), .disc_en(disc_en),
      .min_brk_len(min_brk_len), .brk_pulse(brk_pulse), .mode_clr(mode_clr),
      .sync_ok(sync_ok), .edge_err(edge_err)
   );

   always @(negedge clk) begin
      if (brk_pulse) n_brk++;
      if (mode_clr)  n_clr++;
      if (sync_ok)   n_sync++;
      if (mode_clr != brk_pulse) n_mis++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic line(input logic v, input int n);
      rx_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic restart();
      en = 1'b0;
      repeat (3) @(negedge clk);
      en = 1'b1;
      line(1'b1, 5);
   endtask

   task automatic t_reset();
      chk(brk_pulse == 0 && mode_clr == 0, "R1 reset pulses", int'(brk_pulse), 0);
      chk(sync_ok == 0 && edge_err == 0, "R1 reset flags", int'(sync_ok), 0);
   endtask

   task automatic t_break_basic();
      int b0, c0;
      restart(); min_brk_len = CW'(800); disc_en = 1'b1;
      b0 = n_brk; c0 = n_clr;
      line(1'b0, 500); line(1'b1, 8);
      chk(n_brk == b0, "R2 short low no break", n_brk - b0, 0);
      line(1'b0, 800); line(1'b1, 8);
      chk(n_brk == b0 + 1, "R2 exact min is break", n_brk - b0, 1);
      chk(n_clr == c0 + 1, "R3 mode clear count", n_clr - c0, 1);
   endtask

   task automatic t_sync_nodisc();
      int b0, s0;
      restart(); min_brk_len = CW'(800); disc_en = 1'b0;
      line(1'b0, 1000); line(1'b1, 20);
      b0 = n_brk; s0 = n_sync;
      line(1'b0, 900); line(1'b1, 8);
      chk(n_sync == s0 + 1, "R4 long sync accepted", n_sync - s0, 1);
      chk(n_brk == b0, "R4 no break", n_brk - b0, 0);
   endtask

   task automatic t_sync_disc(input int len, input int exp_sync, input int exp_brk,
                              input int minl, input string tag);
      int b0, s0;
      restart(); min_brk_len = CW'(minl); disc_en = 1'b1;
      line(1'b0, minl + 100); line(1'b1, 20);
      b0 = n_brk; s0 = n_sync;
      line(1'b0, len); line(1'b1, 8);
      chk(n_sync - s0 == exp_sync, {tag, " sync"}, n_sync - s0, exp_sync);
      chk(n_brk - b0 == exp_brk, {tag, " break"}, n_brk - b0, exp_brk);
   endtask

   task automatic t_invalid_then_hunt();
      int s0;
      t_sync_disc(900, 0, 0, 1200, "R7 long short-of-min");
      s0 = n_sync;
      line(1'b0, 100); line(1'b1, 8);
      chk(n_sync == s0, "R7 back to hunting", n_sync - s0, 0);
   endtask

   task automatic t_edges();
      int b0;
      restart(); min_brk_len = CW'(800); disc_en = 1'b1;
      line(1'b0, 1000); line(1'b1, 20);
      repeat (57) begin line(1'b0, 10); line(1'b1, 10); end
      chk(edge_err == 0, "R8 57 edges no error", int'(edge_err), 0);
      line(1'b0, 10); line(1'b1, 10);
      chk(edge_err == 1, "R8 58th edge error", int'(edge_err), 1);
      line(1'b1, 30);
      chk(edge_err == 1, "R8 error sticky", int'(edge_err), 1);
      b0 = n_brk;
      line(1'b0, 1000); line(1'b1, 8);
      chk(n_brk == b0 + 1, "R9 break in frame", n_brk - b0, 1);
      chk(edge_err == 0, "R9 error cleared", int'(edge_err), 0);
   endtask

   task automatic t_disable();
      int b0;
      restart(); min_brk_len = CW'(800);
      en = 1'b0; b0 = n_brk;
      line(1'b0, 1000); line(1'b1, 8);
      chk(n_brk == b0, "R10 no break when off", n_brk - b0, 0);
      chk(!brk_pulse && !sync_ok && !edge_err, "R10 outputs low", int'(sync_ok), 0);
      en = 1'b1;
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_break_basic();
      t_sync_nodisc();
      t_sync_disc(700, 1, 0, 800, "R5 short sync");
      t_sync_disc(749, 1, 0, 800, "R5 boundary 749");
      t_sync_disc(850, 0, 1, 800, "R6 second break");
      t_sync_disc(750, 0, 1, 750, "R6 boundary 750");
      t_invalid_then_hunt();
      t_edges();
      t_disable();
      chk(n_mis == 0, "R3 pulse alignment", n_mis, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule